// File: doc/BRIEF.md
# Baud-Divided SPI Master Transceiver

This block is a master-only serial transceiver. It builds its serial clock from a USART-style baud divider, not a power-of-two prescaler. A single start strobe launches one 8-bit frame. The frame goes out on the data output, most significant bit first. At the same time, a byte is gathered from the data input. The clock rate is fclk / (2·(N+1)), where N is a 12-bit divisor from 0 to 4095. Two control bits choose the clock polarity and the clock phase, which gives the four usual SPI modes. Mode number = {polarity, phase}.

The host drives the start strobe, the transmit byte, the divisor and the two mode bits. It receives the captured byte and a one-cycle done pulse. The divider is reloaded from the divisor input at the start of every transfer. A divisor of 0 therefore toggles the serial clock on every system clock cycle. Changing the polarity or phase bits during a transfer corrupts that frame. The block does not guard against this.

Top module: `usart_spi_master`

## Requirements
- R1: While no transfer is active, `sclk` rests at the level of `cpol` and follows that input at once.
- R2: Every half period of `sclk` during a transfer lasts exactly `divisor`+1 system clock cycles, for any divisor from 0 to 4095.
- R3: A frame has exactly 16 `sclk` edges (8 full clock periods). After the last edge, `sclk` is back at the rest level.
- R4: With `cpol`=0 the leading edge of each period is rising; with `cpol`=1 it is falling. With `cpha`=0, data is sampled on leading edges and changes on trailing edges. With `cpha`=1, data changes on leading edges (except the first) and is sampled on trailing edges.
- R5: The transmit byte is sent most significant bit first. Its bit 7 is on `mosi` in the cycle right after the start is accepted, before the first `sclk` edge. The bit sampled at the k-th sampling edge (k = 0..7) is `tx_data[7-k]`.
- R6: The bit on `miso` at the k-th sampling edge becomes bit 7-k of `rx_data`. `rx_data` changes only in the cycle where `done` is high, and holds its value otherwise.
- R7: `done` is high for exactly one cycle. That cycle directly follows the clock edge that produces the 16th `sclk` edge.
- R8: A `start` pulse during an active transfer is ignored. The running frame completes unchanged, and no second frame follows.
- R9: The divider is loaded at start. The first `sclk` edge appears `divisor`+1 cycles after the cycle in which `start` was sampled.
- R10: After reset, `done` is 0, `rx_data` is 0, and `sclk` is at the rest level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| tx_data | input | 8 | Byte to send, captured at start |
| divisor | input | 12 | Baud divisor N; half period = N+1 cycles |
| cpol | input | 1 | Clock polarity (rest level) |
| cpha | input | 1 | Clock phase |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the cycle in which start was applied. The first `sclk` change is due on falling edge N+1, and each later change N+1 falling edges after the one before it. `done` and the new `rx_data` are due on the same falling edge as the 16th change, and `done` is due low on the next one. `mosi` is read on the falling edge just after each sampling edge. A model slave updates `miso` on the falling edge after each change edge, so the value is stable before the next sampling edge is sampled.

// File: rtl/usm_pkg.sv
package usm_pkg;

    typedef enum logic {
        USM_IDLE = 1'b0,
        USM_RUN  = 1'b1
    } usm_state_e;

    // Per-tick action decoded from the edge index and phase.
    typedef struct packed {
        logic fire;    // an sclk edge happens this cycle
        logic sample;  // capture miso on this edge
        logic shift;   // advance mosi on this edge
        logic last;    // final edge of the frame
    } usm_edge_t;

    // Edge index is zero-based; even indices are leading edges.
    function automatic usm_edge_t usm_decode(
        input logic       fire,
        input logic [7:0] idx,
        input logic [7:0] last_idx,
        input logic       cpha
    );
        usm_edge_t d;
        logic      lead;
        lead     = ~idx[0];
        d.fire   = fire;
        d.sample = fire & (cpha ? ~lead : lead);
        d.shift  = fire & (cpha ? (lead & (idx != 8'd0)) : ~lead);
        d.last   = fire & (idx == last_idx);
        return d;
    endfunction

endpackage

// File: rtl/usm_baud.sv
module usm_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= divisor;
        end else if (run) begin
            if (cnt == '0) cnt <= divisor;
            else           cnt <= cnt - 1'b1;
        end
    end

    // R2: the running count never exceeds a steady divisor
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(load) && $stable(divisor)) |-> (cnt <= divisor));

    // R9: right after a load the count equals the loaded divisor
    p_reload_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(divisor)));

endmodule

// File: rtl/usm_seq.sv
module usm_seq
    import usm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      tick,
    input  logic      cpha,
    output logic      active,
    output logic      load,
    output logic      sclk_lvl,
    output usm_edge_t ev
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    usm_state_e    state;
    logic [EW-1:0] ecnt;

    assign active = (state == USM_RUN);
    assign load   = (state == USM_IDLE) && start;
    assign ev     = usm_decode(active && tick, 8'(ecnt), 8'(EDGES - 1), cpha);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= USM_IDLE;
            ecnt     <= '0;
            sclk_lvl <= 1'b0;
        end else begin
            unique case (state)
                USM_IDLE: begin
                    sclk_lvl <= 1'b0;
                    ecnt     <= '0;
                    if (start) state <= USM_RUN;
                end
                USM_RUN: begin
                    if (ev.fire) begin
                        sclk_lvl <= ~sclk_lvl;
                        ecnt     <= ecnt + 1'b1;
                        if (ev.last) begin
                            state <= USM_IDLE;
                            ecnt  <= '0;
                        end
                    end
                end
                default: state <= USM_IDLE;
            endcase
        end
    end

    // R1: clock level is at rest whenever idle
    p_idle_rest_r1: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk_lvl);

    // R2: the clock level only moves on a divider tick
    p_toggle_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk_lvl) |-> $past(tick && active));

    // R8: a start during a transfer does not restart the edge count
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
        (active && start && !tick) |=> (active && $stable(ecnt)));

endmodule

// File: rtl/usm_shift.sv
module usm_shift
    import usm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] tx_data,
    input  usm_edge_t    ev,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;
    logic [W-1:0] rx_next;

    assign rx_next = {rx_sh[W-2:0], miso};
    assign rx_word = ev.sample ? rx_next : rx_sh;
    assign mosi    = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load)          tx_sh <= tx_data;
            else if (ev.shift) tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (ev.sample)     rx_sh <= rx_next;
        end
    end

    // R5: the top bit of the loaded byte leads on mosi
    p_msb_first_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (mosi == $past(tx_data[W-1])));

    // R4: mosi never changes on a sampling edge
    p_opposite_edges_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.sample && !load) |=> $stable(mosi));

endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
    import usm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              cpol,
    input  logic              cpha,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic              tick;
    logic              active;
    logic              load;
    logic              sclk_lvl;
    usm_edge_t         ev;
    logic [DATA_W-1:0] rx_word;

    usm_baud #(.DIV_W(DIV_W)) i_baud (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .run     (active),
        .divisor (divisor),
        .tick    (tick)
    );

    usm_seq #(.DATA_W(DATA_W)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tick     (tick),
        .cpha     (cpha),
        .active   (active),
        .load     (load),
        .sclk_lvl (sclk_lvl),
        .ev       (ev)
    );

    usm_shift #(.W(DATA_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .tx_data (tx_data),
        .ev      (ev),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

    assign sclk = cpol ^ sclk_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            rx_data <= '0;
        end else begin
            done <= ev.last;
            if (ev.last) rx_data <= rx_word;
        end
    end

    // R1: idle clock rests at the polarity level
    p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
        !active |-> (sclk == cpol));

    // R7: done never lasts more than one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: when done shows, the frame is over and the clock is at rest
    p_done_at_rest_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && (sclk == cpol)));

    // R6: the received byte only moves together with done
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> done);

endmodule

// File: tb/test_usart_spi_master.sv
`timescale 1ns/1ps
module test_usart_spi_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [11:0] divisor = '0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [7:0]  rx_data;
    logic        done;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit over   = 1'b0;

    localparam int WATCHDOG = 190000;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    usart_spi_master i_usart_spi_master (
        .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
        .divisor(divisor), .cpol(cpol), .cpha(cpha), .rx_data(rx_data),
        .done(done), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // One frame: mode = {cpol,cpha}, n = divisor, poke_edge >= 0 sends a stray start
    task automatic xfer(input int mode, input int n, input logic [7:0] tx,
                        input logic [7:0] rxv, input int poke_edge);
        logic pol;
        logic pha;
        logic prev;
        int   k;
        int   gap;
        bit   idle_ok;
        pol = mode[1];
        pha = mode[0];
        @(negedge clk);
        cpol = pol; cpha = pha; divisor = 12'(n);
        tx_data = tx; miso = rxv[7]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tx_data = ~tx;
        chk(mosi == tx[7], "R5 first bit", int'(mosi), int'(tx[7]));
        k = 0; gap = 0; prev = sclk;
        while (k < 16) begin
            @(negedge clk);
            gap++;
            start = (poke_edge >= 0 && k == poke_edge && gap == 1);
            if (sclk !== prev) begin
                if (k == 0) chk(gap == n + 1, "R9 first edge delay", gap, n + 1);
                else        chk(gap == n + 1, "R2 half period", gap, n + 1);
                if (k % 2 == 0) chk(sclk == !pol, "R4 leading edge direction", int'(sclk), int'(!pol));
                else            chk(sclk == pol, "R4 trailing edge direction", int'(sclk), int'(pol));
                if ((pha == 1'b0) == (k % 2 == 0))
                    chk(mosi == tx[7 - k / 2], "R5 bit at sampling edge", int'(mosi), int'(tx[7 - k / 2]));
                if (!pha && (k % 2 == 1) && k < 15) miso = rxv[7 - (k + 1) / 2];
                if (pha && (k % 2 == 0) && k > 0)   miso = rxv[7 - k / 2];
                if (k == 7) chk(done == 1'b0, "R7 done early", int'(done), 0);
                if (k == 15) begin
                    chk(done == 1'b1, "R7 done on last edge", int'(done), 1);
                    chk(rx_data == rxv, "R6 received byte", int'(rx_data), int'(rxv));
                    chk(sclk == pol, "R3 rest after frame", int'(sclk), int'(pol));
                end
                prev = sclk;
                gap  = 0;
                k++;
            end else if (gap > n + 2) begin
                chk(1'b0, "R3 missing edge", k, 16);
                k = 16;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        idle_ok = 1'b1;
        for (int i = 0; i < 2 * (n + 1) + 3; i++) begin
            @(negedge clk);
            if (sclk != pol || done) idle_ok = 1'b0;
        end
        if (poke_edge >= 0) chk(idle_ok, "R8 no second frame", int'(idle_ok), 1);
        else                chk(idle_ok, "R1 idle after frame", int'(idle_ok), 1);
        chk(rx_data == rxv, "R6 byte held", int'(rx_data), int'(rxv));
    endtask

    initial begin
        wait (cycles >= WATCHDOG);
        if (!over) begin
            over = 1'b1;
            chk(1'b0, "watchdog", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10 done after reset", int'(done), 0);
        chk(rx_data == 8'h00, "R10 rx after reset", int'(rx_data), 0);
        chk(sclk == 1'b0, "R10 rest level", int'(sclk), 0);
        cpol = 1'b1;
        #0.5;
        chk(sclk == 1'b1, "R1 idle follows polarity", int'(sclk), 1);
        @(negedge clk);
        cpol = 1'b0;
        #0.5;
        chk(sclk == 1'b0, "R1 idle follows polarity", int'(sclk), 0);

        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 3; d++) begin
                for (int b = 0; b < 2; b++) begin
                    int          idx;
                    logic [7:0]  txb;
                    logic [7:0]  rxb;
                    idx = m * 6 + d * 2 + b;
                    txb = 8'(8'h3C + 37 * idx);
                    rxb = 8'((idx * 91 + 8'hA1) ^ 8'h55);
                    xfer(m, (d == 2) ? 3 : d, txb, rxb, -1);
                end
            end
        end
        xfer(0, 0, 8'hFF, 8'h00, -1);
        xfer(3, 0, 8'h00, 8'hFF, -1);
        xfer(1, 2, 8'h96, 8'h5A, 5);
        xfer(2, 0, 8'h81, 8'h7E, 3);
        xfer(3, 4095, 8'hC3, 8'h81, -1);

        if (!over) begin
            over = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule